// File: doc/BRIEF.md
# Input Delay Tap Training Controller

This block finds the best sampling point for a source-synchronous serial receiver whose data input passes through a programmable delay line with 32 taps. On a training request it walks the tap from 0 up to 31. For each tap it drives the tap bus, pulses a load strobe, and then listens to a downstream video-sync checker. The checker reports a lock flag and a status code together with a result-valid strobe.

A run of adjacent taps that all lock with the same status code forms a window. Each window is closed when lock is lost, when the locked code changes, or when the sweep ends while still locked. The widest closed window is kept. After the last tap, the controller loads the centre of that window and raises `done`. If no window at least two taps wide was found, it loads tap 0 and raises `fail`. A cycle timeout turns a silent checker into an unlocked result, so the sweep always completes.

Top module: `tap_train_ctrl`

## Requirements
- R1: When idle, a one-cycle pulse on `train_req` starts a sweep. The sweep asserts `tap_ld` for exactly one cycle per tap, with `tap_val` = 0, 1, …, 31 in ascending order. `tap_val` is meaningful only while `tap_ld` is high.
- R2: After each tap load, the first SETTLE_CNT strobes on `res_vld` (default 2) are discarded. The `res_lock`/`res_code` values at the next strobe judge the tap.
- R3: A locked result that follows an unlocked one opens a window at that tap. Later locked results with an equal code move the window's upper end to the current tap.
- R4: A locked result whose code differs from the previous locked code closes the current window and opens a new one at the current tap.
- R5: An unlocked result that follows a locked one closes the current window with its last lower and upper ends.
- R6: If tap 31 is locked with the same code as tap 30, the window is closed with 31 as its upper end.
- R7: A closed window replaces the stored best only if its width (upper − lower) is strictly larger. On a tie the earlier window stays. `win_lo`/`win_hi` show the stored best window.
- R8: After tap 31, if a best window exists, one more `tap_ld` pulse carries floor((win_lo + win_hi) / 2). `done` rises in the next cycle and stays high until the next training start.
- R9: If no window of width ≥ 1 was stored, the final `tap_ld` pulse carries 0. `fail` rises in the next cycle, `done` stays low, and `win_lo` = `win_hi` = 0.
- R10: If no `res_vld` strobe arrives for TIMEOUT_CYC cycles (default 64) while waiting on a tap, that tap counts as unlocked and the sweep moves on.
- R11: `train_req` is ignored during a sweep. A new start clears `done`, `fail`, `win_lo` and `win_hi` by the following cycle.
- R12: While reset is held and right after it, `tap_ld`, `done` and `fail` are low and `win_lo` = `win_hi` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_req | input | 1 | Start a training sweep (accepted only when idle) |
| res_vld | input | 1 | Result strobe from the sync checker |
| res_lock | input | 1 | Checker lock flag, valid with res_vld |
| res_code | input | CODE_W | Checker status code, valid with res_vld |
| tap_val | output | TAP_W | Tap value for the delay line |
| tap_ld | output | 1 | One-cycle load strobe for tap_val |
| done | output | 1 | Training finished with a centred tap |
| fail | output | 1 | Training found no usable window |
| win_lo | output | TAP_W | Lower end of the stored best window |
| win_hi | output | TAP_W | Upper end of the stored best window |

## Verification
A fault in the window tracker only shows up at the ports when a window closes. A missed code change or lock loss, or a wrong upper end at tap 31, changes `win_lo`/`win_hi` once that window is compared. The centre pulse after tap 31 then shows the same error. A fault in the sweep sequencer shows up at once as a tap load out of order, a missing load, or an extra load, which the scoreboard catches on the pulse itself. Faults in the settle count or the timeout only change the outcome for taps where the discarded strobes differ from the judged strobe, or where the checker stays silent. The patterns include both of these cases.

// File: rtl/tap_train_pkg.sv
package tap_train_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOAD   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_SAMPLE = 3'd3,
    ST_APPLY  = 3'd4
  } sweep_st_t;
endpackage

// File: rtl/tap_sweep_fsm.sv
module tap_sweep_fsm
  import tap_train_pkg::*;
#(
  parameter int TAP_W       = 5,
  parameter int CODE_W      = 3,
  parameter int SETTLE_CNT  = 2,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              train_req,
  input  logic              res_vld,
  input  logic              res_lock,
  input  logic [CODE_W-1:0] res_code,
  output sweep_st_t         st,
  output logic [TAP_W-1:0]  tap_cnt,
  output logic              sweep_clr,
  output logic              smp_vld,
  output logic              smp_lock,
  output logic [CODE_W-1:0] smp_code,
  output logic              smp_last
);
  localparam int SET_W    = (SETTLE_CNT > 1) ? $clog2(SETTLE_CNT) : 1;
  localparam int SET_LAST = (SETTLE_CNT > 0) ? SETTLE_CNT - 1 : 0;
  localparam int TMR_W    = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [TAP_W-1:0] TAP_LAST = '1;

  sweep_st_t          st_q, st_d;
  logic [TAP_W-1:0]   tap_q, tap_d;
  logic [SET_W-1:0]   set_q, set_d;
  logic [TMR_W-1:0]   tmr_q, tmr_d;
  logic               timeout;

  always_comb begin
    st_d     = st_q;
    tap_d    = tap_q;
    set_d    = set_q;
    tmr_d    = tmr_q;
    smp_vld  = 1'b0;
    smp_lock = 1'b0;
    timeout  = (tmr_q == TMR_W'(TIMEOUT_CYC - 1)) && !res_vld;
    unique case (st_q)
      ST_IDLE: begin
        if (train_req) begin
          st_d  = ST_LOAD;
          tap_d = '0;
        end
      end
      ST_LOAD: begin
        set_d = '0;
        tmr_d = '0;
        st_d  = (SETTLE_CNT == 0) ? ST_SAMPLE : ST_SETTLE;
      end
      ST_SETTLE: begin
        if (res_vld) begin
          tmr_d = '0;
          if (set_q == SET_W'(SET_LAST)) st_d = ST_SAMPLE;
          else                           set_d = set_q + 1'b1;
        end else if (timeout) begin
          smp_vld = 1'b1;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_SAMPLE: begin
        if (res_vld || timeout) begin
          smp_vld  = 1'b1;
          smp_lock = res_vld && res_lock;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_APPLY: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    if (smp_vld) begin
      if (tap_q == TAP_LAST) begin
        st_d = ST_APPLY;
      end else begin
        tap_d = tap_q + 1'b1;
        st_d  = ST_LOAD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tap_q <= '0;
      set_q <= '0;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tap_q <= tap_d;
      set_q <= set_d;
      tmr_q <= tmr_d;
    end
  end

  assign st        = st_q;
  assign tap_cnt   = tap_q;
  assign sweep_clr = (st_q == ST_IDLE) && train_req;
  assign smp_code  = res_code;
  assign smp_last  = smp_vld && (tap_q == TAP_LAST);
endmodule

// File: rtl/eye_window_track.sv
module eye_window_track #(
  parameter int TAP_W  = 5,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              smp_vld,
  input  logic              smp_lock,
  input  logic [CODE_W-1:0] smp_code,
  input  logic [TAP_W-1:0]  smp_tap,
  input  logic              smp_last,
  output logic              rpt_vld,
  output logic [TAP_W-1:0]  rpt_lo,
  output logic [TAP_W-1:0]  rpt_hi
);
  logic              prv_lock_q, prv_lock_d;
  logic [CODE_W-1:0] prv_code_q, prv_code_d;
  logic [TAP_W-1:0]  lo_q, lo_d, hi_q, hi_d;

  always_comb begin
    prv_lock_d = prv_lock_q;
    prv_code_d = prv_code_q;
    lo_d       = lo_q;
    hi_d       = hi_q;
    rpt_vld    = 1'b0;
    rpt_lo     = lo_q;
    rpt_hi     = hi_q;
    if (smp_vld) begin
      prv_lock_d = smp_lock;
      prv_code_d = smp_code;
      if (prv_lock_q) begin
        if (smp_lock && (smp_code == prv_code_q)) begin
          hi_d = smp_tap;
          if (smp_last) begin
            rpt_vld = 1'b1;
            rpt_hi  = smp_tap;
          end
        end else if (smp_lock) begin
          rpt_vld = 1'b1;
          lo_d    = smp_tap;
          hi_d    = smp_tap;
        end else begin
          rpt_vld = 1'b1;
        end
      end else if (smp_lock) begin
        lo_d = smp_tap;
        hi_d = smp_tap;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv_lock_q <= 1'b0;
      prv_code_q <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
    end else if (clr) begin
      prv_lock_q <= 1'b0;
      prv_code_q <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
    end else begin
      prv_lock_q <= prv_lock_d;
      prv_code_q <= prv_code_d;
      lo_q       <= lo_d;
      hi_q       <= hi_d;
    end
  end
endmodule

// File: rtl/eye_best_keep.sv
module eye_best_keep #(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rpt_vld,
  input  logic [TAP_W-1:0] rpt_lo,
  input  logic [TAP_W-1:0] rpt_hi,
  output logic [TAP_W-1:0] best_lo,
  output logic [TAP_W-1:0] best_hi,
  output logic [TAP_W-1:0] best_mid,
  output logic             found
);
  localparam int SUM_W = TAP_W + 1;

  logic [TAP_W-1:0] lo_q, hi_q, rpt_w, best_w;
  logic [SUM_W-1:0] sum_q;
  logic             fnd_q, take;

  always_comb begin
    rpt_w  = rpt_hi - rpt_lo;
    best_w = hi_q - lo_q;
    take   = rpt_vld && (rpt_w > best_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      sum_q <= '0;
      fnd_q <= 1'b0;
    end else if (clr) begin
      lo_q  <= '0;
      hi_q  <= '0;
      sum_q <= '0;
      fnd_q <= 1'b0;
    end else if (take) begin
      lo_q  <= rpt_lo;
      hi_q  <= rpt_hi;
      sum_q <= {1'b0, rpt_hi} + {1'b0, rpt_lo};
      fnd_q <= 1'b1;
    end
  end

  assign best_lo  = lo_q;
  assign best_hi  = hi_q;
  assign best_mid = sum_q[SUM_W-1:1];
  assign found    = fnd_q;
endmodule

// File: rtl/tap_train_ctrl.sv
module tap_train_ctrl
  import tap_train_pkg::*;
#(
  parameter int TAP_W       = 5,
  parameter int CODE_W      = 3,
  parameter int SETTLE_CNT  = 2,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              train_req,
  input  logic              res_vld,
  input  logic              res_lock,
  input  logic [CODE_W-1:0] res_code,
  output logic [TAP_W-1:0]  tap_val,
  output logic              tap_ld,
  output logic              done,
  output logic              fail,
  output logic [TAP_W-1:0]  win_lo,
  output logic [TAP_W-1:0]  win_hi
);
  sweep_st_t         st;
  logic [TAP_W-1:0]  tap_cnt, rpt_lo, rpt_hi, best_mid;
  logic [CODE_W-1:0] smp_code;
  logic              sweep_clr, smp_vld, smp_lock, smp_last, rpt_vld, found;
  logic              done_q, done_d, fail_q, fail_d;

  tap_sweep_fsm #(
    .TAP_W(TAP_W), .CODE_W(CODE_W), .SETTLE_CNT(SETTLE_CNT), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .train_req(train_req),
    .res_vld(res_vld), .res_lock(res_lock), .res_code(res_code),
    .st(st), .tap_cnt(tap_cnt), .sweep_clr(sweep_clr),
    .smp_vld(smp_vld), .smp_lock(smp_lock), .smp_code(smp_code), .smp_last(smp_last)
  );

  eye_window_track #(.TAP_W(TAP_W), .CODE_W(CODE_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .clr(sweep_clr),
    .smp_vld(smp_vld), .smp_lock(smp_lock), .smp_code(smp_code),
    .smp_tap(tap_cnt), .smp_last(smp_last),
    .rpt_vld(rpt_vld), .rpt_lo(rpt_lo), .rpt_hi(rpt_hi)
  );

  eye_best_keep #(.TAP_W(TAP_W)) u_best (
    .clk(clk), .rst_n(rst_n), .clr(sweep_clr),
    .rpt_vld(rpt_vld), .rpt_lo(rpt_lo), .rpt_hi(rpt_hi),
    .best_lo(win_lo), .best_hi(win_hi), .best_mid(best_mid), .found(found)
  );

  always_comb begin
    done_d = done_q;
    fail_d = fail_q;
    if (sweep_clr) begin
      done_d = 1'b0;
      fail_d = 1'b0;
    end else if (st == ST_APPLY) begin
      done_d = found;
      fail_d = !found;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end

  assign tap_ld  = (st == ST_LOAD) || (st == ST_APPLY);
  assign tap_val = (st == ST_APPLY) ? (found ? best_mid : '0) : tap_cnt;
  assign done    = done_q;
  assign fail    = fail_q;
endmodule

// File: rtl/tap_train_chk.sv
module tap_train_chk #(
  parameter int TAP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sweep_clr,
  input logic             tap_ld,
  input logic [TAP_W-1:0] tap_val,
  input logic             done,
  input logic             fail,
  input logic [TAP_W-1:0] win_lo,
  input logic [TAP_W-1:0] win_hi
);
  logic [TAP_W-1:0] wid;
  logic [TAP_W:0]   mid_full;
  assign wid      = win_hi - win_lo;
  assign mid_full = ({1'b0, win_lo} + {1'b0, win_hi}) >> 1;

  a_r1_ld_single: assert property (@(posedge clk) disable iff (!rst_n)
    tap_ld |=> !tap_ld);

  a_r7_win_order: assert property (@(posedge clk) disable iff (!rst_n)
    win_lo <= win_hi);

  a_r7_width_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !sweep_clr |=> (wid >= $past(wid)));

  a_r8_centre_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(tap_ld) && ($past(tap_val) == mid_full[TAP_W-1:0])));

  a_r9_fail_tap0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> ($past(tap_ld) && ($past(tap_val) == '0)));

  a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
endmodule

bind tap_train_ctrl tap_train_chk #(.TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sweep_clr(sweep_clr), .tap_ld(tap_ld), .tap_val(tap_val),
  .done(done), .fail(fail), .win_lo(win_lo), .win_hi(win_hi)
);

// File: tb/sim_tap_train_ctrl.sv
module sim_tap_train_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       train_req = 1'b0;
  logic       res_vld = 1'b0;
  logic       res_lock = 1'b0;
  logic [2:0] res_code = 3'd0;
  logic [4:0] tap_val, win_lo, win_hi;
  logic       tap_ld, done, fail;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int pat = 0;
  int mute_tap = -1;
  bit poison = 0;
  int exp_tap[$];
  string exp_tag[$];

  always #10 clk = ~clk;

  tap_train_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .train_req(train_req), .res_vld(res_vld),
    .res_lock(res_lock), .res_code(res_code), .tap_val(tap_val), .tap_ld(tap_ld),
    .done(done), .fail(fail), .win_lo(win_lo), .win_hi(win_hi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void eye(input int p, input int t, output logic lk, output logic [2:0] cd);
    lk = 1'b0; cd = 3'd0;
    case (p)
      1, 8: if (t >= 5 && t <= 20) begin lk = 1; cd = 3'd2; end
      2: begin
        if (t >= 3 && t <= 9)   begin lk = 1; cd = 3'd1; end
        if (t >= 10 && t <= 24) begin lk = 1; cd = 3'd4; end
      end
      3: if (t <= 8 || t >= 20) begin lk = 1; cd = 3'd3; end
      4: if ((t >= 2 && t <= 7) || (t >= 15 && t <= 20)) begin lk = 1; cd = 3'd5; end
      6: if (t == 9) begin lk = 1; cd = 3'd1; end
      7: if (t >= 4 && t <= 25) begin lk = 1; cd = 3'd1; end
      default: ;
    endcase
  endfunction

  // responder: models the sync checker, one strobe every 4 cycles per tap
  initial begin
    int cur = 0;
    int dv = 0;
    int sn = 0;
    logic lk;
    logic [2:0] cd;
    forever begin
      @(negedge clk);
      res_vld = 1'b0;
      if (tap_ld) begin
        cur = tap_val; dv = 0; sn = 0;
      end else begin
        dv++;
        if (dv == 4) begin
          dv = 0;
          if (cur != mute_tap) begin
            eye(pat, cur, lk, cd);
            if (poison && sn < 2) begin lk = 1'b1; cd = 3'd7; end
            res_vld = 1'b1; res_lock = lk; res_code = cd;
            sn++;
          end
        end
      end
    end
  end

  // monitor: pops expected loads
  initial begin
    forever begin
      @(negedge clk);
      if (tap_ld) begin
        if (exp_tap.size() == 0) chk(1'b0, "R1 unexpected load", tap_val, -1);
        else begin
          int e;
          string g;
          e = exp_tap.pop_front();
          g = exp_tag.pop_front();
          chk(tap_val == e, g, tap_val, e);
        end
      end
    end
  end

  task automatic run_pat(input int p, input int mt, input bit psn, input bit midreq,
                         input int lo, input int hi, input int mid, input bit xfail,
                         input string tag);
    int w;
    pat = p; mute_tap = mt; poison = psn;
    for (int t = 0; t < 32; t++) begin exp_tap.push_back(t); exp_tag.push_back("R1 sweep order"); end
    exp_tap.push_back(xfail ? 0 : mid);
    exp_tag.push_back(xfail ? "R9 fail tap" : {"R8 centre ", tag});
    @(negedge clk); train_req = 1'b1;
    @(negedge clk); train_req = 1'b0;
    chk(!done && !fail && win_lo == 0 && win_hi == 0, "R11 start clears", {done, fail, win_lo, win_hi}, 0);
    w = 0;
    while (!(done || fail) && w < 4000) begin
      @(negedge clk);
      w++;
      train_req = (midreq && w == 100);
    end
    train_req = 1'b0;
    chk(w < 4000, "R10 sweep completes", w, 4000);
    chk(done == !xfail, {"R8 done ", tag}, done, !xfail);
    chk(fail == xfail, {"R9 fail ", tag}, fail, xfail);
    chk(win_lo == lo, {"R7 win_lo ", tag}, win_lo, lo);
    chk(win_hi == hi, {"R7 win_hi ", tag}, win_hi, hi);
    chk(exp_tap.size() == 0, {"R1 load count ", tag}, exp_tap.size(), 0);
    exp_tap.delete(); exp_tag.delete();
    repeat (5) @(negedge clk);
    chk(done == !xfail && fail == xfail, {"R8 flags held ", tag}, {done, fail}, {!xfail, xfail});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!tap_ld && !done && !fail && win_lo == 0 && win_hi == 0, "R12 in reset", tap_ld, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tap_ld && !done && !fail && win_lo == 0 && win_hi == 0, "R12 after reset", tap_ld, 0);
    run_pat(1, -1, 0, 1, 5, 20, 12, 0, "R3 R5 R11 single window, mid-sweep request");
    run_pat(2, -1, 0, 0, 10, 24, 17, 0, "R4 code change");
    run_pat(3, -1, 0, 0, 20, 31, 25, 0, "R6 window at last tap");
    run_pat(4, -1, 0, 0, 2, 7, 4, 0, "R7 tie keeps first");
    run_pat(5, -1, 0, 0, 0, 0, 0, 1, "R9 no lock");
    run_pat(6, -1, 0, 0, 0, 0, 0, 1, "R9 single tap");
    run_pat(7, 12, 0, 0, 13, 25, 19, 0, "R10 silent tap");
    run_pat(8, -1, 1, 0, 5, 20, 12, 0, "R2 settle discard");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule